// File: doc/BRIEF.md
# Master Clock Failure Detector

This block watches an asynchronous high-frequency audio master clock from the free-running system-clock domain. It decides whether that clock is present and running at the expected rate. The monitored clock first passes through a two-flop synchronizer. Its rising edges then mark out measurement windows of 32 edges each. Within each window the block counts ticks of a prescaled system clock. At the end of the window it latches the count and tests it against a programmable minimum and maximum.

Software writes one 32-bit control word to set the bounds, the prescaler and three output enables. It reads the same word back, with the latched count in the top byte. It clears the sticky failure flag by writing a 1 to bit 0 of the status port. The flag comes out of reset set. Software must therefore clear it and wait longer than one window before trusting it. A stopped clock is caught by saturation of the tick counter. The flag drives three requests: an interrupt, an automatic clock switch and a mute. Each request has its own enable.

Top module: `clkfail_mon`

## Requirements
- R1: After reset the failure flag is 1, the control word reads 0 (all bounds, the prescaler select, all enables and the latched count are zero), and all three request outputs are 0.
- R2: Control word layout is: maximum bound in bits 23:16, minimum bound in bits 15:8, irq enable in bit 4, switch enable in bit 5, mute enable in bit 6, and prescaler select in bits 3:0. Bit 7 reads 0. Bits 31:24 read the latched count and ignore writes.
- R3: With prescaler select n, a tick occurs in every cycle where the low n bits of a free-running 8-bit cycle counter (zero at reset) are all ones. This divides the clock by 2^n. A written select above 8 is stored and read back as 8.
- R4: The monitored clock passes through two synchronizer flops, and each rising edge is seen by the counting logic in the third system clock after it is sampled. A window ends on the 32nd counted edge.
- R5: At the end of a window, bits 31:24 take the number of ticks that occurred since the previous window end. Ticks in the end cycle itself are not counted. The value holds until the next window end or overflow.
- R6: At a window end, the failure flag is set if the count is below the minimum or above the maximum. The flag is sticky.
- R7: Writing the status port with bit 0 = 1 clears the flag. Bit 0 = 0 has no effect. A failure detected in the same cycle takes priority and leaves the flag set.
- R8: A tick that arrives while the running count is 255 and no window is ending is an overflow. On an overflow the latched count becomes 255, the flag is set, and both the tick count and the edge count restart from zero.
- R9: The irq, switch and mute requests each equal the failure flag ANDed with that request's own enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| monClk | input | 1 | Monitored master clock, asynchronous |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 32 | Control word write data |
| cfgRdData | output | 32 | Control word readback including latched count |
| stsWrEn | input | 1 | Status write strobe |
| stsWrData | input | 32 | Status write data, bit 0 clears the flag |
| failFlag | output | 1 | Sticky clock failure flag |
| irqReq | output | 1 | Interrupt request |
| switchReq | output | 1 | Clock autoswitch request |
| muteReq | output | 1 | Mute request |

## Verification
The bench sweeps the monitored-clock period against several prescaler settings. One of these runs a window longer than 255 ticks, so overflow fires before the 32nd edge. A design that failed to saturate would wrap the count and report an in-range value for a clock that is far too slow. The monitored clock is also stopped outright. A detector without overflow would then freeze the flag and the count, and never notice the stopped clock. The bench also probes the register edges. It writes a select above 8, writes into the read-only count byte, and issues a status write with bit 0 low. A design that mishandled any of these would read back a corrupt field or lose the flag.

// File: rtl/clkfail_pkg.sv
package clkfail_pkg;
  localparam int CNT_W  = 8;   // width of bounds and measured count
  localparam int PS_W   = 4;   // width of prescaler select field
  localparam int PS_MAX = 8;   // largest legal prescaler exponent

  typedef struct packed {
    logic [CNT_W-1:0] maxB;
    logic [CNT_W-1:0] minB;
    logic             muteEn;
    logic             swEn;
    logic             irqEn;
    logic [PS_W-1:0]  psel;
  } cfg_t;

  // strobes from datapath to control
  typedef struct packed {
    logic             done;
    logic             fail;
    logic [CNT_W-1:0] count;
  } meas_t;
endpackage

// File: rtl/clkfail_datapath.sv
module clkfail_datapath
  import clkfail_pkg::*;
#(
  parameter int EDGES       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  monClk,
  input  cfg_t  cfg,
  output meas_t meas
);
  localparam int EW = $clog2(EDGES);
  localparam logic [CNT_W-1:0] SAT  = '1;
  localparam logic [EW-1:0]    LAST = EW'(EDGES - 1);

  logic [SYNC_STAGES:0] syncQ;
  logic [CNT_W-1:0]     divCnt, divMask, acc;
  logic [EW-1:0]        edgeCnt;
  logic                 monEdge, tick, winEnd, ovf;

  // synchronizer chain plus one flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], monClk};
  end
  assign monEdge = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  // prescaler: free-running counter, tick on low n bits all ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    if (int'(cfg.psel) >= CNT_W) divMask = '1;
    else divMask = (CNT_W'(1) << cfg.psel) - CNT_W'(1);
  end
  assign tick = (divCnt & divMask) == divMask;

  assign winEnd = monEdge && (edgeCnt == LAST);
  assign ovf    = !winEnd && tick && (acc == SAT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      edgeCnt <= '0;
    end else if (winEnd || ovf) begin
      acc     <= '0;
      edgeCnt <= '0;
    end else begin
      if (monEdge) edgeCnt <= edgeCnt + 1'b1;
      if (tick)    acc     <= acc + 1'b1;
    end
  end

  always_comb begin
    meas.done  = winEnd || ovf;
    meas.count = ovf ? SAT : acc;
    meas.fail  = ovf || (acc < cfg.minB) || (acc > cfg.maxB);
  end

  // R8
  sat_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc == SAT) && tick |=> acc == '0);

  // R4
  win_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    meas.done |=> edgeCnt == '0);
endmodule

// File: rtl/clkfail_ctrl.sv
module clkfail_ctrl
  import clkfail_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  input  logic        stsWrEn,
  input  logic [31:0] stsWrData,
  input  meas_t       meas,
  output cfg_t        cfg,
  output logic [31:0] cfgRdData,
  output logic        failFlag,
  output logic        irqReq,
  output logic        switchReq,
  output logic        muteReq
);
  logic [CNT_W-1:0] cntReg;
  logic [PS_W-1:0]  wrPsel;
  logic             clrReq, setReq;

  assign wrPsel = (int'(cfgWrData[PS_W-1:0]) > PS_MAX) ? PS_W'(PS_MAX)
                                                        : cfgWrData[PS_W-1:0];
  assign clrReq = stsWrEn && stsWrData[0];
  assign setReq = meas.done && meas.fail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (cfgWrEn) begin
      cfg.maxB   <= cfgWrData[23:16];
      cfg.minB   <= cfgWrData[15:8];
      cfg.muteEn <= cfgWrData[6];
      cfg.swEn   <= cfgWrData[5];
      cfg.irqEn  <= cfgWrData[4];
      cfg.psel   <= wrPsel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg   <= '0;
      failFlag <= 1'b1;
    end else begin
      if (meas.done) cntReg <= meas.count;
      if (setReq)      failFlag <= 1'b1;
      else if (clrReq) failFlag <= 1'b0;
    end
  end

  assign cfgRdData = {cntReg, cfg.maxB, cfg.minB, 1'b0,
                      cfg.muteEn, cfg.swEn, cfg.irqEn, cfg.psel};
  assign irqReq    = failFlag & cfg.irqEn;
  assign switchReq = failFlag & cfg.swEn;
  assign muteReq   = failFlag & cfg.muteEn;

  // R6
  fail_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    meas.done && meas.fail |=> failFlag);

  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    failFlag && !clrReq |=> failFlag);

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !meas.done |=> $stable(cntReg));
endmodule

// File: rtl/clkfail_mon.sv
module clkfail_mon
  import clkfail_pkg::*;
#(
  parameter int EDGES       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        monClk,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  input  logic        stsWrEn,
  input  logic [31:0] stsWrData,
  output logic        failFlag,
  output logic        irqReq,
  output logic        switchReq,
  output logic        muteReq
);
  cfg_t  cfg;
  meas_t meas;

  clkfail_datapath #(.EDGES(EDGES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .monClk(monClk), .cfg(cfg), .meas(meas)
  );

  clkfail_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .stsWrEn(stsWrEn), .stsWrData(stsWrData),
    .meas(meas), .cfg(cfg), .cfgRdData(cfgRdData),
    .failFlag(failFlag), .irqReq(irqReq),
    .switchReq(switchReq), .muteReq(muteReq)
  );
endmodule

// File: tb/clkfail_mon_tb.sv
module clkfail_mon_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        monClk = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        stsWrEn = 1'b0;
  logic [31:0] stsWrData = '0;
  logic [31:0] cfgRdData;
  logic        failFlag, irqReq, switchReq, muteReq;

  int testsRun = 0;
  int testsFailed = 0;
  int monHalf = 0;
  int monPh = 0;
  bit checking = 1'b0;
  string phase = "R1";

  // behavioural reference state
  int mMax, mMin, mPs, mIrq, mSw, mMute, mCnt, mFail, acc, ecnt, divc;
  int hist[$];

  always #5 clk = ~clk;

  clkfail_mon u_dut (
    .clk(clk), .rstN(rstN), .monClk(monClk),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .stsWrEn(stsWrEn), .stsWrData(stsWrData),
    .failFlag(failFlag), .irqReq(irqReq),
    .switchReq(switchReq), .muteReq(muteReq)
  );

  // monitored clock generator, half period in system cycles (0 = stopped)
  always @(negedge clk) begin
    if (monHalf > 0) begin
      monPh = monPh + 1;
      if (monPh >= monHalf) begin
        monPh = 0;
        monClk = ~monClk;
      end
    end
  end

  // reference model, one step per system clock
  always @(posedge clk) begin
    if (!rstN) begin
      mMax = 0; mMin = 0; mPs = 0; mIrq = 0; mSw = 0; mMute = 0;
      mCnt = 0; mFail = 1; acc = 0; ecnt = 0; divc = 0;
      hist = '{0, 0, 0};
    end else begin
      int mask;
      bit edgeSeen, tick, done, bad;
      edgeSeen = (hist[1] == 1) && (hist[2] == 0);
      mask = (1 << mPs) - 1;
      tick = ((divc & mask) == mask);
      done = 0; bad = 0;
      if (edgeSeen && ecnt == 31) begin
        done = 1; mCnt = acc; bad = (acc < mMin) || (acc > mMax);
        acc = 0; ecnt = 0;
      end else if (tick && acc == 255) begin
        done = 1; mCnt = 255; bad = 1; acc = 0; ecnt = 0;
      end else begin
        if (edgeSeen) ecnt = ecnt + 1;
        if (tick) acc = acc + 1;
      end
      if (done && bad) mFail = 1;
      else if (stsWrEn && stsWrData[0]) mFail = 0;
      if (cfgWrEn) begin
        mMax = int'(cfgWrData[23:16]);
        mMin = int'(cfgWrData[15:8]);
        mPs  = (int'(cfgWrData[3:0]) > 8) ? 8 : int'(cfgWrData[3:0]);
        mIrq = int'(cfgWrData[4]);
        mSw  = int'(cfgWrData[5]);
        mMute = int'(cfgWrData[6]);
      end
      divc = (divc + 1) % 256;
      hist.push_front(int'(monClk));
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s (phase %s) act=%h exp=%h at %0t", req, phase, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (checking && rstN) begin
      logic [31:0] expRd;
      expRd = {mCnt[7:0], mMax[7:0], mMin[7:0], 1'b0, mMute[0], mSw[0], mIrq[0], mPs[3:0]};
      chk("R5 count", {24'h0, cfgRdData[31:24]}, {24'h0, expRd[31:24]});
      chk("R2 cfg", {8'h0, cfgRdData[23:0]}, {8'h0, expRd[23:0]});
      chk("R6 flag", {31'h0, failFlag}, {31'h0, mFail[0]});
      chk("R9 req", {29'h0, irqReq, switchReq, muteReq},
          {29'h0, mFail[0] & mIrq[0], mFail[0] & mSw[0], mFail[0] & mMute[0]});
    end
  end

  task automatic wrCfg(input logic [31:0] v);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic wrSts(input logic [31:0] v);
    @(negedge clk); stsWrEn = 1'b1; stsWrData = v;
    @(negedge clk); stsWrEn = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired act=running exp=done");
    finishRun();
  end

  initial begin
    waitCyc(3);
    // R1: reset values while reset is held
    chk("R1 flag", {31'h0, failFlag}, 32'h1);
    chk("R1 rd", cfgRdData, 32'h0);
    chk("R1 req", {29'h0, irqReq, switchReq, muteReq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 flag after release", {31'h0, failFlag}, 32'h1);
    checking = 1'b1;

    phase = "R5";
    wrCfg(32'h00FF0008);
    monHalf = 2;
    waitCyc(400);

    phase = "R7";
    wrSts(32'h0000FFFE);
    waitCyc(5);
    wrSts(32'h00000001);
    waitCyc(10);

    phase = "R6";
    wrCfg(32'h008C6470);
    waitCyc(200);
    wrSts(32'h1);
    waitCyc(400);

    phase = "R9";
    monHalf = 1;
    waitCyc(200);
    wrCfg(32'h008C6410);
    waitCyc(20);
    wrCfg(32'h008C6420);
    waitCyc(20);
    wrCfg(32'h008C6440);
    waitCyc(20);

    phase = "R8";
    monHalf = 0;
    wrSts(32'h1);
    waitCyc(300);
    wrSts(32'h1);
    waitCyc(300);

    phase = "R3";
    wrCfg(32'hAB00FF0F);
    monHalf = 3;
    waitCyc(1000);
    wrCfg(32'h00FF0002);
    waitCyc(600);
    wrCfg(32'h00322801);
    monHalf = 2;
    wrSts(32'h1);
    waitCyc(400);

    phase = "R4";
    wrCfg(32'h00AA9600);
    monHalf = 5;
    wrSts(32'h1);
    waitCyc(900);
    wrCfg(32'h00AA9601);
    wrSts(32'h1);
    waitCyc(400);
    wrSts(32'h1);
    waitCyc(700);

    checking = 1'b0;
    finishRun();
  end
endmodule